// File: doc/BRIEF.md
# Multiframe Q-Channel Register Interface

This block is the register-side logic for S/T multiframing in a line transceiver that runs either on the network side (NT) or on the terminal side (TE). Software writes a 4-bit transmit nibble through a byte-wide register port. In NT mode that nibble carries subchannel 1. In TE mode it carries the Q channel. At every multiframe-start strobe the block copies the nibble into a transmit latch. The framer supplies the current frame index, and the block drives the matching latched bit onto `tx_bit`, most significant bit first, in frames 0, 5, 10 and 15 of the 20-frame multiframe. If software does not rewrite the nibble, the same bits go out again in the next multiframe. A write in the middle of a multiframe does not change the bits already being sent.

In NT mode the block also takes a received Q nibble and a qualifier flag from the line side, at most once per multiframe, and shows them in a read-only field. A sticky interrupt is raised either at every multiframe start or whenever a new Q nibble is accepted. A configuration bit in the receive register picks which of the two.

Top module: `mfq_regif`

## Requirements
- R1: Addresses 0 and 1 are legacy slots. A read there returns 0xFF, and a write there changes no other register.
- R2: Address 2 holds the transmit nibble in bits 7:4, with bit 7 as the nibble's MSB. Bits 3:0 of address 2 read as 0.
- R3: With `mf_enable` high, the nibble is copied into the transmit latch on the clock edge where `mf_start` is high. A write between two strobes does not change `tx_bit` until the next strobe.
- R4: If the nibble is not rewritten, the next multiframe sends the same four bits again.
- R5: A hardware reset (`rst_n` low) or a software reset (`sw_reset` high) sets both the nibble and the latch to 0000 when `nt_mode`=1 and to 1111 when `nt_mode`=0.
- R6: With `nt_mode`=1 and `mf_enable`=1, the first `rx_valid` pulse after each `mf_start` loads `rx_nib` into bits 7:4 of address 3. Further pulses in the same multiframe, pulses in TE mode, and writes to address 3 bits 7:3 have no effect on that field.
- R7: Bit 3 of address 3 holds the `rx_qual` value captured together with the nibble in NT mode. In TE mode, bits 7:3 of address 3 read as 0.
- R8: Bit 2 of address 3 is a read/write select. When it is 1, the interrupt flag sets at each `mf_start` while `mf_enable` is high. When it is 0, the flag sets on each accepted Q nibble. Bits 1:0 read as 0.
- R9: `irq` is sticky. A read of address 3 (`reg_rd` high) clears it on that clock edge, unless a new set event occurs in the same cycle, in which case it stays set.
- R10: With `mf_enable`=1, `tx_bit` carries latch bits 3, 2, 1, 0 in frames 0, 5, 10, 15 and 1 in every other frame. With `mf_enable`=0, `tx_bit` is 1 and strobes leave the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| sw_reset | input | 1 | Synchronous software reset, active high |
| nt_mode | input | 1 | 1 = network side, 0 = terminal side |
| mf_enable | input | 1 | Multiframing enabled |
| mf_start | input | 1 | One-cycle strobe at the multiframe boundary |
| frame_idx | input | 5 | Frame index within the multiframe, from the framer |
| rx_valid | input | 1 | A received Q nibble is present |
| rx_nib | input | 4 | Received Q nibble |
| rx_qual | input | 1 | Qualifier flag for the received nibble |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| tx_bit | output | 1 | Transmit Q/subchannel bit for the current frame |
| irq | output | 1 | Sticky multiframe interrupt |

## Verification
A latch that loads at the wrong moment shows up on `tx_bit` in the next Q frame after the faulty edge. The bench therefore reads all four slot bits right after each strobe, and again after a write in the middle of a multiframe. A capture guard that fails to block a second nibble shows up in the next read of address 3, within one cycle of the extra pulse. A wrong reset value shows up in the first read of address 2 and in the first slot after a strobe. A flag that fails to hold or fails to clear shows up on `irq` one cycle after the read or strobe concerned.

// File: rtl/mfq_pkg.sv
package mfq_pkg;
    localparam int unsigned ADDR_W     = 2;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned NIB_W      = 4;
    localparam int unsigned MF_FRAMES  = 20;
    localparam int unsigned SLOT_GAP   = 5;

    localparam int unsigned ADDR_LEG0  = 0;
    localparam int unsigned ADDR_LEG1  = 1;
    localparam int unsigned ADDR_TXNIB = 2;
    localparam int unsigned ADDR_RXNIB = 3;
endpackage

// File: rtl/mfq_tx_path.sv
module mfq_tx_path #(
    parameter int unsigned NIB_W     = 4,
    parameter int unsigned MF_FRAMES = 20,
    parameter int unsigned SLOT_GAP  = 5,
    localparam int unsigned FIDX_W   = $clog2(MF_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              nt_mode,
    input  logic              mf_enable,
    input  logic              mf_start,
    input  logic              wr_en,
    input  logic [NIB_W-1:0]  wr_nib,
    input  logic [FIDX_W-1:0] frame_idx,
    output logic [NIB_W-1:0]  cur_nib,
    output logic [NIB_W-1:0]  latch_nib,
    output logic              tx_bit
);
    typedef struct packed {
        logic [NIB_W-1:0] nib;
        logic [NIB_W-1:0] latch;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic [NIB_W-1:0] rst_val;

    assign rst_val = nt_mode ? '0 : '1;

    always_comb begin
        s_d = s_q;
        if (wr_en)
            s_d.nib = wr_nib;
        if (mf_start && mf_enable)
            s_d.latch = s_q.nib;
        if (sw_reset) begin
            s_d.nib   = rst_val;
            s_d.latch = rst_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.nib   <= rst_val;
            s_q.latch <= rst_val;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        tx_bit = 1'b1;
        if (mf_enable) begin
            for (int k = 0; k < int'(NIB_W); k++) begin
                if (frame_idx == FIDX_W'(k * int'(SLOT_GAP)))
                    tx_bit = s_q.latch[NIB_W-1-k];
            end
        end
    end

    assign cur_nib   = s_q.nib;
    assign latch_nib = s_q.latch;

    // R4: without a strobe the latch keeps its value from one cycle to the next
    p_latch_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mf_start && !sw_reset) |=> $stable(s_q.latch));
endmodule

// File: rtl/mfq_rx_path.sv
module mfq_rx_path #(
    parameter int unsigned NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             nt_mode,
    input  logic             mf_enable,
    input  logic             mf_start,
    input  logic             rx_valid,
    input  logic [NIB_W-1:0] rx_nib,
    input  logic             rx_qual,
    input  logic             cfg_wr,
    input  logic             cfg_every,
    input  logic             rd_clear,
    output logic [NIB_W-1:0] q_nib,
    output logic             q_qual,
    output logic             every_en,
    output logic             irq
);
    typedef struct packed {
        logic [NIB_W-1:0] nib;
        logic             qual;
        logic             got;
        logic             every;
        logic             flag;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic accept;
    logic set_ev;

    always_comb begin
        s_d    = s_q;
        accept = nt_mode && mf_enable && rx_valid && (!s_q.got || mf_start);
        set_ev = mf_enable && ((s_q.every && mf_start) || (!s_q.every && accept));
        if (mf_start)
            s_d.got = 1'b0;
        if (accept) begin
            s_d.nib  = rx_nib;
            s_d.qual = rx_qual;
            s_d.got  = 1'b1;
        end
        if (cfg_wr)
            s_d.every = cfg_every;
        if (rd_clear)
            s_d.flag = 1'b0;
        if (set_ev)
            s_d.flag = 1'b1;
        if (sw_reset)
            s_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign q_nib    = s_q.nib;
    assign q_qual   = s_q.qual;
    assign every_en = s_q.every;
    assign irq      = s_q.flag;

    // R6: once a nibble has been taken, the field holds until the next boundary
    p_capture_once_r6: assert property (@(posedge clk) disable iff (!rst_n || sw_reset)
        (s_q.got && !mf_start) |=> $stable(s_q.nib));

    // R9: the flag stays set until it is read
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n || sw_reset)
        (irq && !rd_clear) |=> irq);

    // R6: terminal-side pulses never touch the captured field
    p_te_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n || sw_reset)
        (!nt_mode) |=> $stable(s_q.nib));
endmodule

// File: rtl/mfq_regif.sv
module mfq_regif
    import mfq_pkg::*;
#(
    parameter int unsigned AW        = ADDR_W,
    parameter int unsigned DW        = DATA_W,
    parameter int unsigned NW        = NIB_W,
    parameter int unsigned FRAMES    = MF_FRAMES,
    parameter int unsigned GAP       = SLOT_GAP,
    localparam int unsigned FW       = $clog2(FRAMES),
    localparam int unsigned QUAL_BIT = DW - NW - 1,
    localparam int unsigned EVRY_BIT = DW - NW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_reset,
    input  logic          nt_mode,
    input  logic          mf_enable,
    input  logic          mf_start,
    input  logic [FW-1:0] frame_idx,
    input  logic          rx_valid,
    input  logic [NW-1:0] rx_nib,
    input  logic          rx_qual,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          tx_bit,
    output logic          irq
);
    logic          sel_tx, sel_rx, sel_leg;
    logic [NW-1:0] tx_nib, tx_latch, q_nib;
    logic          q_qual, every_en;

    assign sel_tx  = (reg_addr == AW'(ADDR_TXNIB));
    assign sel_rx  = (reg_addr == AW'(ADDR_RXNIB));
    assign sel_leg = (reg_addr == AW'(ADDR_LEG0)) || (reg_addr == AW'(ADDR_LEG1));

    mfq_tx_path #(.NIB_W(NW), .MF_FRAMES(FRAMES), .SLOT_GAP(GAP)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_reset  (sw_reset),
        .nt_mode   (nt_mode),
        .mf_enable (mf_enable),
        .mf_start  (mf_start),
        .wr_en     (reg_wr && sel_tx),
        .wr_nib    (reg_wdata[DW-1 -: NW]),
        .frame_idx (frame_idx),
        .cur_nib   (tx_nib),
        .latch_nib (tx_latch),
        .tx_bit    (tx_bit)
    );

    mfq_rx_path #(.NIB_W(NW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_reset  (sw_reset),
        .nt_mode   (nt_mode),
        .mf_enable (mf_enable),
        .mf_start  (mf_start),
        .rx_valid  (rx_valid),
        .rx_nib    (rx_nib),
        .rx_qual   (rx_qual),
        .cfg_wr    (reg_wr && sel_rx),
        .cfg_every (reg_wdata[EVRY_BIT]),
        .rd_clear  (reg_rd && sel_rx),
        .q_nib     (q_nib),
        .q_qual    (q_qual),
        .every_en  (every_en),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_leg) begin
            reg_rdata = '1;
        end else if (sel_tx) begin
            reg_rdata[DW-1 -: NW] = tx_nib;
        end else if (sel_rx) begin
            if (nt_mode) begin
                reg_rdata[DW-1 -: NW] = q_nib;
                reg_rdata[QUAL_BIT]   = q_qual;
            end
            reg_rdata[EVRY_BIT] = every_en;
        end
    end

    // R3: the latch moves only on an enabled strobe (or a reset)
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mf_start && mf_enable) && !sw_reset) |=> $stable(tx_latch));

    // R10: the line bit idles high while multiframing is off
    p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_enable |-> tx_bit);

    // R5: after a software reset the nibble holds the mode's reset value
    p_reset_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sw_reset) && ($past(nt_mode) == nt_mode)) |->
            (tx_nib == (nt_mode ? {NW{1'b0}} : {NW{1'b1}})));

    // R1: legacy reads always return all ones
    p_legacy_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_leg |-> (reg_rdata == {DW{1'b1}}));
endmodule

// File: tb/tb_mfq_regif.sv
module tb_mfq_regif;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0;
    logic       nt_mode = 1'b1;
    logic       mf_enable = 1'b1;
    logic       mf_start = 1'b0;
    logic [4:0] frame_idx = '0;
    logic       rx_valid = 1'b0;
    logic [3:0] rx_nib = '0;
    logic       rx_qual = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_bit;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    mfq_regif dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .nt_mode(nt_mode),
        .mf_enable(mf_enable), .mf_start(mf_start), .frame_idx(frame_idx),
        .rx_valid(rx_valid), .rx_nib(rx_nib), .rx_qual(rx_qual),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_bit(tx_bit), .irq(irq)
    );

    typedef struct packed {
        logic       do_wr;
        logic [3:0] nib;
        logic [3:0] exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 4'hA, 4'hA},
        '{1'b0, 4'h0, 4'hA},
        '{1'b1, 4'h3, 4'h3},
        '{1'b1, 4'hF, 4'hF},
        '{1'b0, 4'h0, 4'hF},
        '{1'b1, 4'h0, 4'h0},
        '{1'b1, 4'h9, 4'h9}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd(input logic [1:0] a);
        reg_rd = 1'b1; reg_addr = a;
        cyc();
        reg_rd = 1'b0;
    endtask

    task automatic mf();
        mf_start = 1'b1;
        cyc();
        mf_start = 1'b0;
    endtask

    task automatic rx(input logic [3:0] n, input logic q);
        rx_valid = 1'b1; rx_nib = n; rx_qual = q;
        cyc();
        rx_valid = 1'b0;
    endtask

    task automatic slots(output logic [3:0] n);
        for (int k = 0; k < 4; k++) begin
            frame_idx = 5'(k * 5);
            #1 n[3-k] = tx_bit;
        end
        frame_idx = 5'd1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [3:0] s;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R5: hardware reset in NT mode
        peek(2'd2, v); check("R5 nt hw reset nibble", v, 8'h00);
        check("R9 irq after reset", {7'h0, irq}, 8'h00);

        // R3 R4 R10: walk the table of multiframes
        foreach (VECS[i]) begin
            if (VECS[i].do_wr) wr(2'd2, {VECS[i].nib, 4'h0});
            mf();
            slots(s);
            check($sformatf("R3/R4 vector %0d slot bits", i), {4'h0, s}, {4'h0, VECS[i].exp});
        end
        frame_idx = 5'd7; #1;
        check("R10 non-slot frame", {7'h0, tx_bit}, 8'h01);

        // R2: low bits read as zero
        wr(2'd2, 8'h9F);
        peek(2'd2, v); check("R2 tx register readback", v, 8'h90);

        // R3: write between strobes is not seen until the next one
        wr(2'd2, 8'h50);
        slots(s); check("R3 mid-multiframe write ignored", {4'h0, s}, 8'h09);
        mf();
        slots(s); check("R3 new value after strobe", {4'h0, s}, 8'h05);

        // R1: legacy slots
        wr(2'd0, 8'h12);
        wr(2'd1, 8'h34);
        peek(2'd0, v); check("R1 legacy 0 read", v, 8'hFF);
        peek(2'd1, v); check("R1 legacy 1 read", v, 8'hFF);
        peek(2'd2, v); check("R1 tx reg untouched", v, 8'h50);
        peek(2'd3, v); check("R1 rx reg untouched", v, 8'h00);

        // R10: disabled multiframing idles high and holds the latch
        mf_enable = 1'b0;
        slots(s); check("R10 disabled slots high", {4'h0, s}, 8'h0F);
        wr(2'd2, 8'h20);
        mf();
        mf_enable = 1'b1;
        slots(s); check("R10 latch held while disabled", {4'h0, s}, 8'h05);
        mf();
        slots(s); check("R10 latch follows after enable", {4'h0, s}, 8'h02);

        // R6 R7 R8: capture once per multiframe, new-nibble interrupt
        rx(4'h6, 1'b1);
        peek(2'd3, v); check("R7 capture with qualifier", v, 8'h68);
        check("R8 irq on new nibble", {7'h0, irq}, 8'h01);
        rx(4'hC, 1'b0);
        peek(2'd3, v); check("R6 second nibble ignored", v, 8'h68);
        rd(2'd3);
        check("R9 read clears irq", {7'h0, irq}, 8'h00);
        mf();
        check("R8 no strobe irq when select is 0", {7'h0, irq}, 8'h00);
        rx(4'hC, 1'b0);
        peek(2'd3, v); check("R6 capture in next multiframe", v, 8'hC0);
        rd(2'd3);

        // R6 R8: select bit, read-only upper field
        wr(2'd3, 8'hFC);
        peek(2'd3, v); check("R6 R8 write only sets select", v, 8'hC4);
        check("R8 no irq from config write", {7'h0, irq}, 8'h00);
        mf();
        check("R8 irq at strobe", {7'h0, irq}, 8'h01);

        // R9: set wins over a simultaneous read
        reg_rd = 1'b1; reg_addr = 2'd3; mf_start = 1'b1;
        cyc();
        reg_rd = 1'b0; mf_start = 1'b0;
        check("R9 set beats clear", {7'h0, irq}, 8'h01);
        rd(2'd3);
        check("R9 cleared afterwards", {7'h0, irq}, 8'h00);

        // R7 R6: terminal side masks and ignores
        nt_mode = 1'b0;
        cyc();
        peek(2'd3, v); check("R7 TE masks upper field", v, 8'h04);
        rx(4'h3, 1'b1);
        nt_mode = 1'b1;
        cyc();
        peek(2'd3, v); check("R6 TE pulse not captured", v, 8'hC4);

        // R5: software reset in TE mode
        nt_mode = 1'b0;
        cyc();
        sw_reset = 1'b1;
        cyc();
        sw_reset = 1'b0;
        peek(2'd2, v); check("R5 te sw reset nibble", v, 8'hF0);
        slots(s); check("R5 te sw reset latch", {4'h0, s}, 8'h0F);
        peek(2'd3, v); check("R5 sw reset clears select", v, 8'h00);

        // R5: software reset in NT mode
        nt_mode = 1'b1;
        cyc();
        sw_reset = 1'b1;
        cyc();
        sw_reset = 1'b0;
        peek(2'd2, v); check("R5 nt sw reset nibble", v, 8'h00);

        // R5: hardware reset in TE mode
        nt_mode = 1'b0;
        wr(2'd2, 8'h30);
        rst_n = 1'b0;
        repeat (2) cyc();
        rst_n = 1'b1;
        cyc();
        peek(2'd2, v); check("R5 te hw reset nibble", v, 8'hF0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule